// File: doc/BRIEF.md
# Wired-AND Interrupt Bus Arbitration Agent

This block is one contender on a shared interrupt bus made of two open-drain wires with pull-ups. Any agent may pull a wire low and no agent ever drives it high. When its requester has an interrupt to deliver and the bus reports idle, the agent starts a five-cycle contest on the bus clock. In the first cycle it pulls wire 0 low to mark the start. In the four cycles after that, it pulls wire 1 low for every 1 bit of its 4-bit priority code. The code is read from bits 27 down to 24 of a 32-bit identity word. At the end of each cycle the agent samples wire 1. If the agent left the wire released but finds it low, a rival is pulling it, and the agent withdraws.

Wire 1 being low at the end of the first cycle has a special meaning: another agent opened an end-of-interrupt transfer on the same edge. That also counts as a loss. An agent that survives all five cycles raises a one-cycle win pulse, and its requester then owns the bus. After any attempt, whether won or lost, the agent stays silent until the bus has been seen busy and then idle again. If the request is still held at that point, it competes once more. The block produces only the two pull-down enables. The value driven is always 0, and the wired-AND resolution happens outside the block. The payload phase after a win is handled elsewhere.

The request is a plain level held by the requester, not a valid/ready stream. No payload enters or leaves here, so there is no back-pressure. The requester keeps `arb_req` high until it sees `won`. After a loss it may keep the request high and let the agent retry.

Top module: `irq_bus_arbiter`

## Requirements
- R1: An attempt begins on a rising edge at which `arb_req` and `bus_idle` are both high and the agent is re-armed. Cycle 1 of the attempt is the clock period that follows that edge.
- R2: In cycle 1, `drv0_oe` is high and `drv1_oe` is low. `drv0_oe` is high for exactly that one cycle of the attempt.
- R3: If `line1_in` is low at the end of cycle 1 (a concurrent end-of-interrupt start), the agent loses. `lost` pulses in the next cycle, and both enables and `busy` are low from then on.
- R4: In cycles 2, 3, 4 and 5, `drv0_oe` is low. `drv1_oe` is high exactly when `id_reg` bit 27, 26, 25 or 24 respectively is 1, so the most significant code bit goes first.
- R5: If the agent has `drv1_oe` low in one of cycles 2 to 5 and samples `line1_in` low at the end of that cycle, `lost` pulses for one cycle after it. Both enables and `busy` stay low from that cycle on.
- R6: An attempt that finishes cycle 5 without a loss gives a `won` pulse of exactly one cycle, in the cycle right after cycle 5. `won` and `lost` are never high together.
- R7: Bits of `id_reg` other than 27 down to 24 have no effect on any output.
- R8: After an attempt ends, no new attempt starts until `bus_idle` has been low on at least one rising edge. A still-held request then competes again at the next edge where `bus_idle` is high.
- R9: While `arb_req` is low or `bus_idle` is low, no attempt starts and both enables stay low.
- R10: `busy` is high exactly during the cycles of an attempt. During and after reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the contest advances on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| arb_req | input | 1 | Level request from the interrupt source, held until `won` |
| bus_idle | input | 1 | High while the shared bus carries no transfer |
| id_reg | input | 32 | Identity word; bits 27..24 are the priority code |
| line1_in | input | 1 | Resolved level of wire 1, synchronous to `clk` |
| drv0_oe | output | 1 | Pull wire 0 low (start marker) |
| drv1_oe | output | 1 | Pull wire 1 low (priority code bit equal to 1) |
| busy | output | 1 | An attempt is in progress |
| won | output | 1 | One-cycle pulse: arbitration won |
| lost | output | 1 | One-cycle pulse: arbitration lost |

## Verification
The hardest states to reach from the ports are a loss deep in the code sequence and the re-arm rule. A loss at cycle 4 or 5 only happens when several agents share their leading code bits. A stalled retry only shows when a losing agent keeps its request while the bus never looks busy. The bench builds the real bus out of three agents whose enables it folds into a wired-AND wire 1. It chooses codes that split at every depth, and it forces wire 1 low during cycle 1 to imitate an end-of-interrupt opener. It then holds `bus_idle` high after a lost contest to show that no restart occurs until a busy period is seen.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  // Agent phase: parked between contests, or inside one.
  typedef enum logic {
    PH_WAIT = 1'b0,
    PH_RUN  = 1'b1
  } arb_phase_e;

  // Width of a slot counter able to hold 0..id_w.
  function automatic int slot_width(input int id_w);
    return $clog2(id_w + 1);
  endfunction

endpackage

// File: rtl/irq_arb_rearm.sv
module irq_arb_rearm
  import irq_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arb_req,
  input  logic       bus_idle,
  input  arb_phase_e phase,
  input  logic       attempt_end,
  output logic       start
);

  // Set by a busy bus, cleared when a contest finishes either way.
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
    end else if (attempt_end) begin
      armed_q <= 1'b0;
    end else if (!bus_idle) begin
      armed_q <= 1'b1;
    end
  end

  assign start = arb_req && bus_idle && armed_q && (phase == PH_WAIT);

  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    attempt_end |=> !start);

endmodule

// File: rtl/irq_arb_seq.sv
module irq_arb_seq
  import irq_arb_pkg::*;
#(
  parameter int ID_W = 4,
  localparam int CNT_W = slot_width(ID_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  output arb_phase_e       phase,
  output logic [CNT_W-1:0] slot,
  output logic             last
);

  // Slot 0 is the start marker, slots 1..ID_W carry the code.
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(ID_W);

  arb_phase_e       phase_q;
  logic [CNT_W-1:0] slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_WAIT;
      slot_q  <= '0;
    end else begin
      unique case (phase_q)
        PH_WAIT: begin
          if (start) begin
            phase_q <= PH_RUN;
            slot_q  <= '0;
          end
        end
        PH_RUN: begin
          if (abort || last) begin
            phase_q <= PH_WAIT;
            slot_q  <= '0;
          end else begin
            slot_q <= slot_q + CNT_W'(1);
          end
        end
        default: begin
          phase_q <= PH_WAIT;
          slot_q  <= '0;
        end
      endcase
    end
  end

  assign phase = phase_q;
  assign slot  = slot_q;
  assign last  = (phase_q == PH_RUN) && (slot_q == LAST_SLOT);

  // R10
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RUN) |-> (slot_q <= LAST_SLOT));

  // R10
  run_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_RUN) && !last && !abort) |=> (phase_q == PH_RUN));

endmodule

// File: rtl/irq_arb_drive.sv
module irq_arb_drive
  import irq_arb_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int ID_LSB = 24,
  parameter int ID_W   = 4,
  localparam int CNT_W = slot_width(ID_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  arb_phase_e       phase,
  input  logic [CNT_W-1:0] slot,
  input  logic             last,
  input  logic [REG_W-1:0] id_reg,
  input  logic             line1_in,
  output logic             drv0_oe,
  output logic             drv1_oe,
  output logic             abort,
  output logic             won,
  output logic             lost
);

  localparam int PAD = 1 << CNT_W;
  localparam logic [REG_W-1:0] ID_MASK =
    ((REG_W'(1) << ID_W) - REG_W'(1)) << ID_LSB;

  // Code bit per slot, most significant first; slot 0 and spare slots read 0.
  logic [PAD-1:0] id_pad;
  for (genvar g = 0; g < PAD; g++) begin : g_pad
    if (g >= 1 && g <= ID_W) begin : g_bit
      assign id_pad[g] = id_reg[ID_LSB + ID_W - g];
    end else begin : g_zero
      assign id_pad[g] = 1'b0;
    end
  end

  logic unused_id_bits;
  assign unused_id_bits = ^(id_reg & ~ID_MASK);

  logic run;
  assign run     = (phase == PH_RUN);
  assign drv0_oe = run && (slot == '0);
  assign drv1_oe = run && id_pad[slot];
  // Released wire read back low: someone else is pulling it.
  assign abort   = run && !drv1_oe && !line1_in;

  logic won_q, lost_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      won_q  <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      won_q  <= last && !abort;
      lost_q <= abort;
    end
  end

  assign won  = won_q;
  assign lost = lost_q;

  // R2
  start_marker_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv0_oe |=> !drv0_oe);

  // R6
  outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(won && lost));

  // R6
  won_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    won |=> !won);

  // R5
  lost_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lost |-> (!drv0_oe && !drv1_oe));

endmodule

// File: rtl/irq_bus_arbiter.sv
module irq_bus_arbiter
  import irq_arb_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int ID_LSB = 24,
  parameter int ID_W   = 4,
  localparam int CNT_W = slot_width(ID_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arb_req,
  input  logic             bus_idle,
  input  logic [REG_W-1:0] id_reg,
  input  logic             line1_in,
  output logic             drv0_oe,
  output logic             drv1_oe,
  output logic             busy,
  output logic             won,
  output logic             lost
);

  arb_phase_e       phase;
  logic [CNT_W-1:0] slot;
  logic             last;
  logic             abort;
  logic             start;
  logic             attempt_end;

  assign attempt_end = abort || last;
  assign busy        = (phase == PH_RUN);

  irq_arb_rearm u_rearm (
    .clk         (clk),
    .rst_n       (rst_n),
    .arb_req     (arb_req),
    .bus_idle    (bus_idle),
    .phase       (phase),
    .attempt_end (attempt_end),
    .start       (start)
  );

  irq_arb_seq #(.ID_W(ID_W)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .abort (abort),
    .phase (phase),
    .slot  (slot),
    .last  (last)
  );

  irq_arb_drive #(.REG_W(REG_W), .ID_LSB(ID_LSB), .ID_W(ID_W)) u_drive (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase),
    .slot     (slot),
    .last     (last),
    .id_reg   (id_reg),
    .line1_in (line1_in),
    .drv0_oe  (drv0_oe),
    .drv1_oe  (drv1_oe),
    .abort    (abort),
    .won      (won),
    .lost     (lost)
  );

  // R1
  start_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(arb_req && bus_idle));

  // R3
  eoi_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv0_oe && !line1_in) |=> (lost && !busy));

  // R5
  released_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !drv1_oe && !line1_in) |=> (lost && !drv0_oe && !drv1_oe));

  // R9
  quiet_when_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!drv0_oe && !drv1_oe));

  // R6
  won_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    won |-> ($past(busy) && !busy));

endmodule

// File: tb/test_irq_bus_arbiter.sv
module test_irq_bus_arbiter;

  localparam int N = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic          bus_idle;
  logic          eoi_pull;
  logic [N-1:0]  req, oe0, oe1, busy, won, lost;
  logic [31:0]   id_r [N];
  logic          line1;

  // Open-drain wire 1 with pull-up, plus an external end-of-interrupt opener.
  assign line1 = ~((|oe1) | eoi_pull);

  int checks = 0;
  int fails  = 0;

  for (genvar k = 0; k < N; k++) begin : g_agent
    irq_bus_arbiter i_irq_bus_arbiter (
      .clk      (clk),
      .rst_n    (rst_n),
      .arb_req  (req[k]),
      .bus_idle (bus_idle),
      .id_reg   (id_r[k]),
      .line1_in (line1),
      .drv0_oe  (oe0[k]),
      .drv1_oe  (oe1[k]),
      .busy     (busy[k]),
      .won      (won[k]),
      .lost     (lost[k])
    );
  end

  task automatic check(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  function automatic logic idbit(input int a, input int n);
    return id_r[a][29 - n];
  endfunction

  task automatic check_quiet(input string rq, input string what);
    for (int a = 0; a < N; a++) begin
      check(rq, $sformatf("%s agent%0d busy", what, a), busy[a], 0);
      check(rq, $sformatf("%s agent%0d drv0", what, a), oe0[a], 0);
      check(rq, $sformatf("%s agent%0d drv1", what, a), oe1[a], 0);
      check(rq, $sformatf("%s agent%0d won", what, a), won[a], 0);
      check(rq, $sformatf("%s agent%0d lost", what, a), lost[a], 0);
    end
  endtask

  // Busy bus for two edges (re-arms every agent), then idle; ends on a negedge.
  task automatic settle();
    req = '0;
    eoi_pull = 1'b0;
    bus_idle = 1'b0;
    repeat (2) @(negedge clk);
    bus_idle = 1'b1;
    @(negedge clk);
  endtask

  // Predicts each agent's fate from the wired-AND rule, then checks every cycle.
  task automatic contest(input logic [N-1:0] mask, input logic eoi,
                         input logic keep_idle, input logic [N-1:0] hold,
                         input string tag);
    int lose_at [N];
    logic [N-1:0] alive;
    logic pull;
    alive = mask;
    for (int a = 0; a < N; a++) lose_at[a] = 0;
    for (int c = 1; c <= 5; c++) begin
      pull = (c == 1) ? eoi : 1'b0;
      for (int a = 0; a < N; a++)
        if (alive[a] && c > 1 && idbit(a, c)) pull = 1'b1;
      for (int a = 0; a < N; a++)
        if (alive[a] && pull && !(c > 1 && idbit(a, c))) begin
          lose_at[a] = c;
          alive[a] = 1'b0;
        end
    end
    req = mask;
    for (int n = 1; n <= 6; n++) begin
      @(negedge clk);
      if (n == 1) begin
        if (!keep_idle) bus_idle = 1'b0;
        eoi_pull = eoi;
      end
      if (n == 2) eoi_pull = 1'b0;
      for (int a = 0; a < N; a++) begin
        logic e_busy, e_d0, e_d1, e_lost, e_won;
        int la;
        la = lose_at[a];
        e_busy = mask[a] && n <= 5 && (la == 0 || n <= la);
        e_d0   = e_busy && n == 1;
        e_d1   = e_busy && n >= 2 && idbit(a, n);
        e_lost = mask[a] && la != 0 && n == la + 1;
        e_won  = mask[a] && la == 0 && n == 6;
        check({"R10 ", tag}, $sformatf("agent%0d busy n=%0d", a, n), busy[a], e_busy);
        check({"R1,R2 ", tag}, $sformatf("agent%0d drv0 n=%0d", a, n), oe0[a], e_d0);
        check({"R4 ", tag}, $sformatf("agent%0d drv1 n=%0d", a, n), oe1[a], e_d1);
        check({eoi ? "R3 " : "R5 ", tag}, $sformatf("agent%0d lost n=%0d", a, n),
              lost[a], e_lost);
        check({"R6 ", tag}, $sformatf("agent%0d won n=%0d", a, n), won[a], e_won);
      end
    end
    req = req & hold;
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    req = '0;
    bus_idle = 1'b0;
    eoi_pull = 1'b0;
    for (int a = 0; a < N; a++) id_r[a] = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    check_quiet("R10", "in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_quiet("R10", "after reset");
  endtask

  task automatic test_solo();
    id_r[0] = 32'h0A00_0000;
    contest(3'b001, 1'b0, 1'b0, 3'b000, "solo");
    settle();
  endtask

  task automatic test_pair();
    id_r[0] = 32'h0900_0000;
    id_r[1] = 32'h0500_0000;
    contest(3'b011, 1'b0, 1'b0, 3'b000, "pair");
    settle();
  endtask

  task automatic test_trio_deep();
    // 0011 / 0010 / 0001: losses at cycle 4 and cycle 5.
    id_r[0] = 32'h0300_0000;
    id_r[1] = 32'h0200_0000;
    id_r[2] = 32'h0100_0000;
    contest(3'b111, 1'b0, 1'b0, 3'b000, "trio");
    settle();
  endtask

  task automatic test_eoi_clash();
    id_r[0] = 32'h0F00_0000;
    id_r[1] = 32'h0700_0000;
    contest(3'b011, 1'b1, 1'b0, 3'b000, "eoi");
    settle();
  endtask

  task automatic test_outside_bits();
    // R7: only bits 27..24 count; every other bit set or cleared at will.
    id_r[0] = 32'hF0FF_FFFF;
    contest(3'b001, 1'b0, 1'b0, 3'b000, "R7 zero-code");
    settle();
    id_r[0] = 32'h0AFF_FFFF;
    id_r[1] = 32'hF900_0000;
    contest(3'b011, 1'b0, 1'b0, 3'b000, "R7 split-cycle4");
    settle();
  endtask

  task automatic test_no_start();
    req = 3'b111;
    bus_idle = 1'b0;
    repeat (4) begin
      @(negedge clk);
      check_quiet("R9", "req high bus busy");
    end
    req = '0;
    bus_idle = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check_quiet("R9", "bus idle no req");
    end
    settle();
  endtask

  task automatic test_retry();
    id_r[0] = 32'h0100_0000;
    id_r[1] = 32'h0800_0000;
    contest(3'b011, 1'b0, 1'b1, 3'b001, "R8 first");
    repeat (4) begin
      @(negedge clk);
      check("R8", "held req, bus never busy: agent0 busy", busy[0], 0);
      check("R8", "held req, bus never busy: agent0 drv0", oe0[0], 0);
    end
    bus_idle = 1'b0;
    @(negedge clk);
    bus_idle = 1'b1;
    check("R9", "bus busy edge: agent0 busy", busy[0], 0);
    @(negedge clk);
    check("R8", "retry cycle1 agent0 busy", busy[0], 1);
    check("R8", "retry cycle1 agent0 drv0", oe0[0], 1);
    repeat (4) @(negedge clk);
    check("R8", "retry cycle5 agent0 drv1 (code bit 24)", oe1[0], 1);
    @(negedge clk);
    check("R8", "retry agent0 won", won[0], 1);
    check("R8", "retry agent0 lost", lost[0], 0);
    settle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish (all requirements)");
    summary();
    $finish;
  end

  initial begin
    test_reset();
    settle();
    test_solo();
    test_pair();
    test_trio_deep();
    test_eoi_clash();
    test_outside_bits();
    test_no_start();
    test_retry();
    summary();
    $finish;
  end

endmodule